// File: doc/BRIEF.md
# Modem Line Status and Control Unit

This block sits beside the register interface of a serial port and handles the four modem handshake inputs and the four modem control outputs. Each input line (clear-to-send, data-set-ready, ring indicate and carrier detect) passes through a multi-flop synchronizer. The block then presents the current level of each line, and a sticky change flag for each line, as one 8-bit status value. The change flags clear when software reads that status value. A modem-status interrupt request is raised while any change flag is set and the modem-status interrupt enable is on.

A 5-bit control register drives the data-terminal-ready and request-to-send outputs and two general-purpose outputs. A fifth bit selects a diagnostic loopback. In loopback the four control bits are routed back onto the status inputs in place of the external lines, and the external outputs are forced inactive. Software can then exercise the whole status and interrupt path without a cable. All levels are active high: 1 means asserted.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, the control register, `stat_q`, all four control outputs and `irq_req` are zero.
- R2: A write with `ctl_wr` loads `ctl_wdata` into the control register at that clock edge. When bit 4 is clear, `dtr_out` follows bit 0, `rts_out` bit 1, `out1_out` bit 2 and `out2_out` bit 3 from the next cycle.
- R3: While control bit 4 (loopback) is set, `dtr_out`, `rts_out`, `out1_out` and `out2_out` are all 0.
- R4: In loopback, status bits 4 to 7 read the control bits: bit 4 (CTS level) = control bit 1, bit 5 (DSR level) = control bit 0, bit 6 (RI level) = control bit 2, bit 7 (DCD level) = control bit 3. They change in the cycle after the write.
- R5: Outside loopback, status bit 4 shows `cts_in`, bit 5 `dsr_in`, bit 6 `ri_in` and bit 7 `dcd_in`, delayed by the two synchronizer stages. A pin value sampled at edge k appears after edge k+1.
- R6: Status bits 0, 1 and 3 are change flags for CTS, DSR and DCD. A flag is set one cycle after its level bit (4, 5 or 7) changes in either direction.
- R7: Status bit 2 is set only when the RI level bit 6 goes from 1 to 0. A rising RI level leaves it unchanged.
- R8: A cycle with `stat_rd` high clears all change flags at the closing edge. A change detected in that same cycle leaves its flag set.
- R9: `irq_req` is 1 exactly when `msi_en` is 1 and at least one of status bits 0 to 3 is 1.
- R10: Without a read, a set change flag stays set whatever the lines do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 5 | Control write data: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback |
| stat_rd | input | 1 | Read strobe of the status value (clears change flags) |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicate line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| out1_out | output | 1 | General-purpose output 1 |
| out2_out | output | 1 | General-purpose output 2 |
| ctl_q | output | 5 | Current control register value |
| stat_q | output | 8 | Status value: bits 0-3 change flags, bits 4-7 line levels |
| irq_req | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach from the ports is a read that lands in exactly the cycle in which a new change is detected, since the flag must then survive the clear. The bench raises a line, counts the two synchronizer edges, and places `stat_rd` in the single cycle before the change flag is latched. A second awkward case is entering or leaving loopback while the external lines differ from the control bits. The source switch itself must then produce change flags. Long random stretches of control writes mixed with pin activity cover this case, and a behavioural model checks every cycle.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int unsigned LINES   = 4;
  localparam int unsigned CTL_W   = 5;
  // control bit positions
  localparam int unsigned C_DTR   = 0;
  localparam int unsigned C_RTS   = 1;
  localparam int unsigned C_OUT1  = 2;
  localparam int unsigned C_OUT2  = 3;
  localparam int unsigned C_LOOP  = 4;
  // line index inside a level vector {DCD, RI, DSR, CTS}
  localparam int unsigned L_CTS   = 0;
  localparam int unsigned L_DSR   = 1;
  localparam int unsigned L_RI    = 2;
  localparam int unsigned L_DCD   = 3;

  // events between two level samples: any toggle, except RI which counts falls only
  function automatic logic [LINES-1:0] line_events(logic [LINES-1:0] prev,
                                                   logic [LINES-1:0] cur);
    logic [LINES-1:0] ev;
    ev        = prev ^ cur;
    ev[L_RI]  = prev[L_RI] & ~cur[L_RI];
    return ev;
  endfunction

  // levels seen by the status side when the control bits are looped back
  function automatic logic [LINES-1:0] loop_levels(logic [CTL_W-1:0] ctl);
    logic [LINES-1:0] l;
    l[L_CTS] = ctl[C_RTS];
    l[L_DSR] = ctl[C_DTR];
    l[L_RI]  = ctl[C_OUT1];
    l[L_DCD] = ctl[C_OUT2];
    return l;
  endfunction
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/msu_ctl.sv
module msu_ctl
  import msu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl,
  output logic             loop_on,
  output logic [LINES-1:0] drive   // {out2, out1, rts, dtr}
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl <= '0;
    else if (wr_en) ctl <= wdata;
  end

  assign loop_on = ctl[C_LOOP];

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_pin
      assign drive[g] = ctl[g] & ~loop_on;
    end
  endgenerate

  // R2: a write without loopback shows up on the pins next cycle
  assert_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[C_LOOP]) |=> (drive == $past(wdata[LINES-1:0])));

  // R3: pins idle in loopback
  assert_loop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[C_LOOP] |-> (drive == '0));
endmodule

// File: rtl/msu_delta.sv
module msu_delta
  import msu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  input  logic             rd,
  output logic [LINES-1:0] flags,
  output logic [LINES-1:0] events
);
  logic [LINES-1:0] prev_lvl;

  assign events = line_events(prev_lvl, lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      flags    <= '0;
    end else begin
      prev_lvl <= lvl;
      flags    <= rd ? events : (flags | events);
    end
  end

  // R6: every detected event is latched one cycle later
  assert_event_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(events)) == $past(events)));

  // R7: RI flag cannot set unless the previous RI level was high
  assert_ri_trailing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_lvl[L_RI] && !flags[L_RI]) |=> !flags[L_RI]);

  // R8: a read with nothing new leaves all flags clear
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && events == '0) |=> (flags == '0));

  // R10: flags are sticky without a read
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [4:0]       ctl_wdata,
  input  logic             stat_rd,
  input  logic             msi_en,
  input  logic             cts_in,
  input  logic             dsr_in,
  input  logic             ri_in,
  input  logic             dcd_in,
  output logic             dtr_out,
  output logic             rts_out,
  output logic             out1_out,
  output logic             out2_out,
  output logic [4:0]       ctl_q,
  output logic [7:0]       stat_q,
  output logic             irq_req
);
  logic [LINES-1:0] pins_raw;
  logic [LINES-1:0] pins_sync;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] flags;
  logic [LINES-1:0] events;
  logic [LINES-1:0] drive;
  logic [CTL_W-1:0] ctl;
  logic             loop_on;

  assign pins_raw[L_CTS] = cts_in;
  assign pins_raw[L_DSR] = dsr_in;
  assign pins_raw[L_RI]  = ri_in;
  assign pins_raw[L_DCD] = dcd_in;

  msu_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync));

  msu_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wdata(ctl_wdata),
    .ctl(ctl), .loop_on(loop_on), .drive(drive));

  assign lvl = loop_on ? loop_levels(ctl) : pins_sync;

  msu_delta u_delta (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rd(stat_rd),
    .flags(flags), .events(events));

  assign dtr_out  = drive[C_DTR];
  assign rts_out  = drive[C_RTS];
  assign out1_out = drive[C_OUT1];
  assign out2_out = drive[C_OUT2];
  assign ctl_q    = ctl;
  assign stat_q   = {lvl, flags};
  assign irq_req  = msi_en & (|flags);

  // R9: request only while enabled and some change is pending
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (msi_en && stat_q[3:0] != 4'b0));

  // R3: external outputs stay quiet in loopback
  assert_top_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> !(dtr_out || rts_out || out1_out || out2_out));
endmodule

// File: tb/modem_status_unit_tb.sv
`timescale 1ns/1ps
module modem_status_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic stat_rd = 1'b0;
  logic msi_en = 1'b0;
  logic cts_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
  logic dtr_out, rts_out, out1_out, out2_out;
  logic [4:0] ctl_q;
  logic [7:0] stat_q;
  logic irq_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stat_rd(stat_rd), .msi_en(msi_en), .cts_in(cts_in), .dsr_in(dsr_in),
    .ri_in(ri_in), .dcd_in(dcd_in), .dtr_out(dtr_out), .rts_out(rts_out),
    .out1_out(out1_out), .out2_out(out2_out), .ctl_q(ctl_q),
    .stat_q(stat_q), .irq_req(irq_req));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [4:0] m_ctl   = '0;
  logic [3:0] m_lvl   = '0;   // {DCD,RI,DSR,CTS}
  logic [3:0] m_prev  = '0;
  logic [3:0] m_flag  = '0;
  logic [3:0] hist[$] = '{4'b0, 4'b0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = '0; m_lvl = '0; m_prev = '0; m_flag = '0;
      hist = '{4'b0, 4'b0};
    end else begin
      logic [3:0] ev;
      for (int i = 0; i < 4; i++) ev[i] = (m_prev[i] != m_lvl[i]);
      ev[2] = (m_prev[2] == 1'b1) && (m_lvl[2] == 1'b0);
      if (stat_rd) m_flag = ev;
      else         m_flag = m_flag | ev;
      m_prev = m_lvl;
      if (ctl_wr) m_ctl = ctl_wdata;
      hist.push_back({dcd_in, ri_in, dsr_in, cts_in});
      void'(hist.pop_front());
      if (m_ctl[4]) m_lvl = {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
      else          m_lvl = hist[0];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] pins_exp;
      pins_exp = m_ctl[4] ? 4'b0 : m_ctl[3:0];
      chk(m_ctl[4] ? "R3 outputs" : "R2 outputs",
          {4'b0, out2_out, out1_out, rts_out, dtr_out}, {4'b0, pins_exp});
      chk("R2 ctl", {3'b0, ctl_q}, {3'b0, m_ctl});
      chk(m_ctl[4] ? "R4 levels" : "R5 levels", {4'b0, stat_q[7:4]}, {4'b0, m_lvl});
      chk("R6 R7 R8 R10 flags", {4'b0, stat_q[3:0]}, {4'b0, m_flag});
      chk("R9 irq", {7'b0, irq_req}, {7'b0, msi_en & (|m_flag)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [4:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; step(); ctl_wr = 1'b0;
  endtask

  task automatic rdst();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1 status", stat_q, 8'h00);
    chk("R1 ctl", {3'b0, ctl_q}, 8'h00);
    chk("R1 irq", {7'b0, irq_req}, 8'h00);
    rst_n = 1'b1;
    step(2);

    // R2: control bits to pins
    wr(5'b00101); step(1);
    chk("R2 dtr/out1", {6'b0, out1_out, dtr_out}, 8'h03);
    wr(5'b01010); step(1);
    chk("R2 rts/out2", {6'b0, out2_out, rts_out}, 8'h03);

    // R5/R6: CTS toggles, flag appears
    cts_in = 1'b1; step(3);
    chk("R5 cts level", {7'b0, stat_q[4]}, 8'h01);
    step(1);
    chk("R6 cts flag", {7'b0, stat_q[0]}, 8'h01);
    dcd_in = 1'b1; step(4);
    chk("R6 dcd flag", {7'b0, stat_q[3]}, 8'h01);
    rdst();
    chk("R8 cleared", {4'b0, stat_q[3:0]}, 8'h00);

    // R7: RI rising does not flag, falling does
    ri_in = 1'b1; step(5);
    chk("R7 ri rise level", {7'b0, stat_q[6]}, 8'h01);
    chk("R7 ri rise no flag", {7'b0, stat_q[2]}, 8'h00);
    ri_in = 1'b0; step(5);
    chk("R7 ri fall flag", {7'b0, stat_q[2]}, 8'h01);

    // R10: flag stays while lines move back
    cts_in = 1'b0; step(6); cts_in = 1'b1; step(6);
    chk("R10 sticky", {7'b0, stat_q[2]}, 8'h01);

    // R9: interrupt with and without enable
    msi_en = 1'b1; step(1);
    chk("R9 irq on", {7'b0, irq_req}, 8'h01);
    rdst();
    chk("R9 irq off", {7'b0, irq_req}, 8'h00);

    // R8: change detected in the read cycle survives
    dsr_in = 1'b1; step(2);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    chk("R8 same-cycle kept", {7'b0, stat_q[1]}, 8'h01);
    rdst();

    // R4/R3: loopback
    wr(5'b10011); step(1);
    chk("R3 pins idle", {4'b0, out2_out, out1_out, rts_out, dtr_out}, 8'h00);
    chk("R4 loop levels", {4'b0, stat_q[7:4]}, 8'h03);
    wr(5'b11100); step(1);
    chk("R4 loop levels 2", {4'b0, stat_q[7:4]}, 8'h0c);
    wr(5'b00000); step(4); rdst();

    // random soak, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 3) == 0)
        {dcd_in, ri_in, dsr_in, cts_in} = 4'($urandom);
      ctl_wr    = ($urandom_range(0, 15) == 0);
      ctl_wdata = 5'($urandom);
      stat_rd   = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 31) == 0) msi_en = ~msi_en;
      step(1);
    end
    ctl_wr = 1'b0; stat_rd = 1'b0;
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog R1-R10 run actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule